// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block sits behind an instruction byte queue and turns a stream of bytes into whole instruction descriptors for a small subset of a 16-bit legacy encoding. It accepts one byte per handshake beat. The opcode byte is looked up in a small internal table that gives its format class: single byte, register/memory operand, or register/memory operand followed by immediate data. The block then collects the addressing byte, any displacement bytes and any immediate bytes in order.

The addressing byte holds three fields. The field in the top two bits and the class from the opcode table together fix how many trailing bytes follow, so an instruction is between 1 and 6 bytes long. Multi-byte fields arrive low byte first and are assembled into 16-bit values. Once the final byte is taken, a descriptor is shown for one cycle. It holds the opcode, the width bit, the three addressing fields, the displacement, the immediate and the byte count. The next byte accepted always starts a new instruction.

Top module: `iparse_top`

## Requirements
- R1: While `rst` is high at a clock edge, the parser returns to the opcode phase and drops any partial instruction; `desc_valid` is low in the cycle after a reset edge.
- R2: `in_ready` is high whenever `rst` is low, and a byte is consumed on each rising edge where `in_valid` and `in_ready` are both high.
- R3: Opcodes 0x50 to 0x57 and 0x90, and every opcode outside the table of R4 and R8, form a complete 1-byte instruction with `desc_len` = 1 and `desc_w` equal to opcode bit 0.
- R4: Opcodes 0x00 to 0x03 and 0x88 to 0x8B are followed by an addressing byte split as mode = bits 7..6, reg = bits 5..3, rm = bits 2..0; `desc_w` is opcode bit 0.
- R5: Mode 11, or mode 00 with rm not equal to 110, adds no displacement bytes; `desc_disp` is 0.
- R6: Mode 01 adds one displacement byte, sign-extended to 16 bits.
- R7: Mode 10, and mode 00 with rm = 110, add two displacement bytes, low byte first.
- R8: Opcodes 0xC6 (8-bit) and 0xC7 (16-bit) take the addressing byte and displacement as in R5 to R7, then the immediate data. With opcode bit 0 = 1 there are two data bytes, low byte first. With bit 0 = 0 there is one data byte, the high byte of `desc_imm` is 0, and `desc_len` does not count a high data byte.
- R9: `desc_valid` is high for exactly the one cycle after the final byte is accepted. The descriptor fields are valid in that cycle. A byte accepted in that same cycle begins a new instruction, so back-to-back instructions need no gap.
- R10: A reset asserted partway through an instruction discards it: no descriptor for it is produced, and the next byte is treated as an opcode.
- R11: Cycles with `in_valid` low between the bytes of one instruction do not change the phase or the collected fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Parser can take a byte |
| in_byte | input | 8 | Instruction byte |
| desc_valid | output | 1 | One-cycle descriptor strobe |
| desc_opcode | output | 8 | Opcode byte |
| desc_w | output | 1 | Operand width bit (opcode bit 0) |
| desc_mod | output | 2 | Addressing mode field |
| desc_reg | output | 3 | Register or opcode-extension field |
| desc_rm | output | 3 | Register/memory selector field |
| desc_disp | output | 16 | Assembled displacement |
| desc_imm | output | 16 | Assembled immediate |
| desc_len | output | 3 | Instruction byte count, 1 to 6 |

## Verification
The assertions assume the byte stream starts on an instruction boundary after reset and that each offered byte is held stable until it is taken. They also assume the upstream queue never inserts prefix bytes, because those are outside the table and would be read as single-byte opcodes. The directed stimulus keeps to these assumptions. It starts every scenario on a boundary and releases `in_valid` only between whole beats. It inserts idle gaps and a mid-instruction reset on purpose, and it checks that the parser realigns on the byte that follows.

// File: rtl/iparse_pkg.sv
package iparse_pkg;

    parameter int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int MOD_W  = 2;
    localparam int SEL_W  = 3;
    localparam int LEN_W  = 3;

    typedef enum logic [1:0] {
        FMT_SINGLE,
        FMT_RM,
        FMT_RM_IMM
    } fmt_e;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_MRM,
        PH_DLO,
        PH_DHI,
        PH_ILO,
        PH_IHI
    } phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        logic              w;
        logic [MOD_W-1:0]  md;
        logic [SEL_W-1:0]  rg;
        logic [SEL_W-1:0]  rm;
        logic [WORD_W-1:0] disp;
        logic [WORD_W-1:0] imm;
        logic [LEN_W-1:0]  len;
    } insn_t;

    // Number of displacement bytes implied by the addressing byte.
    function automatic logic [1:0] disp_count(logic [MOD_W-1:0] md, logic [SEL_W-1:0] rm);
        logic [1:0] n;
        unique case (md)
            2'b00:   n = (rm == 3'b110) ? 2'd2 : 2'd0;
            2'b01:   n = 2'd1;
            2'b10:   n = 2'd2;
            default: n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/iparse_classify.sv
module iparse_classify
    import iparse_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output fmt_e              fmt
);
    always_comb begin
        if (op[7:2] == 6'b000000 || op[7:2] == 6'b100010)
            fmt = FMT_RM;
        else if (op[7:1] == 7'b1100011)
            fmt = FMT_RM_IMM;
        else
            fmt = FMT_SINGLE;
    end
endmodule

// File: rtl/iparse_seq.sv
module iparse_seq
    import iparse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [BYTE_W-1:0] in_byte,
    input  fmt_e              fmt_new,
    output phase_e            phase,
    output logic              last,
    output logic              sext_disp
);
    phase_e     phase_q, phase_n;
    fmt_e       fmt_q;
    logic       w_q;
    logic       two_q;
    logic [1:0] dn;

    assign phase     = phase_q;
    assign sext_disp = ~two_q;
    assign dn        = disp_count(in_byte[7:6], in_byte[2:0]);

    always_comb begin
        phase_n = phase_q;
        last    = 1'b0;
        if (accept) begin
            unique case (phase_q)
                PH_OPC: begin
                    if (fmt_new == FMT_SINGLE) last = 1'b1;
                    else                       phase_n = PH_MRM;
                end
                PH_MRM: begin
                    if (dn != 2'd0)              phase_n = PH_DLO;
                    else if (fmt_q == FMT_RM_IMM) phase_n = PH_ILO;
                    else                          last = 1'b1;
                end
                PH_DLO: begin
                    if (two_q)                    phase_n = PH_DHI;
                    else if (fmt_q == FMT_RM_IMM) phase_n = PH_ILO;
                    else                          last = 1'b1;
                end
                PH_DHI: begin
                    if (fmt_q == FMT_RM_IMM) phase_n = PH_ILO;
                    else                     last = 1'b1;
                end
                PH_ILO: begin
                    if (w_q) phase_n = PH_IHI;
                    else     last = 1'b1;
                end
                PH_IHI:  last = 1'b1;
                default: last = 1'b1;
            endcase
            if (last) phase_n = PH_OPC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_OPC;
            fmt_q   <= FMT_SINGLE;
            w_q     <= 1'b0;
            two_q   <= 1'b0;
        end else begin
            phase_q <= phase_n;
            if (accept && phase_q == PH_OPC) begin
                fmt_q <= fmt_new;
                w_q   <= in_byte[0];
            end
            if (accept && phase_q == PH_MRM)
                two_q <= (dn == 2'd2);
        end
    end

    // R11: no accepted byte, no phase movement
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(phase_q));

    // R8: the high data phase is only reached for 16-bit immediates
    assert_imm_hi_wide_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IHI) |-> (w_q && fmt_q == FMT_RM_IMM));
endmodule

// File: rtl/iparse_fields.sv
module iparse_fields
    import iparse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              last,
    input  logic              sext_disp,
    input  phase_e            phase,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              desc_valid,
    output insn_t             desc
);
    insn_t part_q, part_n;

    always_comb begin
        part_n = part_q;
        if (accept) begin
            unique case (phase)
                PH_OPC: begin
                    part_n        = '0;
                    part_n.opcode = in_byte;
                    part_n.w      = in_byte[0];
                    part_n.len    = LEN_W'(1);
                end
                PH_MRM: begin
                    part_n.md  = in_byte[7:6];
                    part_n.rg  = in_byte[5:3];
                    part_n.rm  = in_byte[2:0];
                    part_n.len = part_q.len + LEN_W'(1);
                end
                PH_DLO: begin
                    part_n.disp = sext_disp ? {{BYTE_W{in_byte[BYTE_W-1]}}, in_byte}
                                            : {{BYTE_W{1'b0}}, in_byte};
                    part_n.len  = part_q.len + LEN_W'(1);
                end
                PH_DHI: begin
                    part_n.disp[WORD_W-1:BYTE_W] = in_byte;
                    part_n.len = part_q.len + LEN_W'(1);
                end
                PH_ILO: begin
                    part_n.imm = {{BYTE_W{1'b0}}, in_byte};
                    part_n.len = part_q.len + LEN_W'(1);
                end
                PH_IHI: begin
                    part_n.imm[WORD_W-1:BYTE_W] = in_byte;
                    part_n.len = part_q.len + LEN_W'(1);
                end
                default: part_n = part_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q     <= '0;
            desc       <= '0;
            desc_valid <= 1'b0;
        end else begin
            part_q     <= part_n;
            desc_valid <= accept && last;
            if (accept && last) desc <= part_n;
        end
    end

    // R3: an instruction that ends on its opcode byte reports one byte
    assert_single_len_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && last && phase == PH_OPC) |=> (desc_valid && desc.len == LEN_W'(1)));

    // R5: register-direct mode never carries a displacement
    assert_reg_nodisp_R5: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc.md == 2'b11) |-> (desc.disp == '0));

    // R6: short displacement is sign-extended
    assert_sext_R6: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc.md == 2'b01)
            |-> (desc.disp[WORD_W-1:BYTE_W] == {BYTE_W{desc.disp[BYTE_W-1]}}));

    // R8: narrow immediate has a zero high byte
    assert_narrow_imm_R8: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && !desc.w) |-> (desc.imm[WORD_W-1:BYTE_W] == '0));

    // R9: byte count stays within 1..6
    assert_len_range_R9: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> (desc.len >= LEN_W'(1) && desc.len <= LEN_W'(6)));
endmodule

// File: rtl/iparse_top.sv
module iparse_top
    import iparse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              desc_valid,
    output logic [BYTE_W-1:0] desc_opcode,
    output logic              desc_w,
    output logic [MOD_W-1:0]  desc_mod,
    output logic [SEL_W-1:0]  desc_reg,
    output logic [SEL_W-1:0]  desc_rm,
    output logic [WORD_W-1:0] desc_disp,
    output logic [WORD_W-1:0] desc_imm,
    output logic [LEN_W-1:0]  desc_len
);
    fmt_e   fmt_new;
    phase_e phase;
    logic   accept;
    logic   last;
    logic   sext_disp;
    insn_t  desc;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    iparse_classify u_classify (
        .op  (in_byte),
        .fmt (fmt_new)
    );

    iparse_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .in_byte   (in_byte),
        .fmt_new   (fmt_new),
        .phase     (phase),
        .last      (last),
        .sext_disp (sext_disp)
    );

    iparse_fields u_fields (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .last       (last),
        .sext_disp  (sext_disp),
        .phase      (phase),
        .in_byte    (in_byte),
        .desc_valid (desc_valid),
        .desc       (desc)
    );

    assign desc_opcode = desc.opcode;
    assign desc_w      = desc.w;
    assign desc_mod    = desc.md;
    assign desc_reg    = desc.rg;
    assign desc_rm     = desc.rm;
    assign desc_disp   = desc.disp;
    assign desc_imm    = desc.imm;
    assign desc_len    = desc.len;

    // R1: a reset edge leaves no descriptor strobe behind it
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !desc_valid);
endmodule

// File: tb/iparse_top_test.sv
`timescale 1ns/1ps
module iparse_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        desc_valid;
    logic [7:0]  desc_opcode;
    logic        desc_w;
    logic [1:0]  desc_mod;
    logic [2:0]  desc_reg;
    logic [2:0]  desc_rm;
    logic [15:0] desc_disp;
    logic [15:0] desc_imm;
    logic [2:0]  desc_len;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    iparse_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .desc_valid(desc_valid), .desc_opcode(desc_opcode),
        .desc_w(desc_w), .desc_mod(desc_mod), .desc_reg(desc_reg),
        .desc_rm(desc_rm), .desc_disp(desc_disp), .desc_imm(desc_imm),
        .desc_len(desc_len)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 1; i < n; i++) begin
            chk("R11", "no strobe while idle", 16'(desc_valid), 16'd0);
            @(negedge clk);
        end
    endtask

    // Sample the strobe cycle, then confirm the strobe drops.
    task automatic expect_desc(string req, logic [7:0] op, logic w, logic [1:0] md,
                               logic [2:0] rg, logic [2:0] rm, logic [15:0] disp,
                               logic [15:0] imm, logic [2:0] len);
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "valid", 16'(desc_valid), 16'd1);
        chk(req, "opcode", 16'(desc_opcode), 16'(op));
        chk(req, "w", 16'(desc_w), 16'(w));
        chk(req, "mod", 16'(desc_mod), 16'(md));
        chk(req, "reg", 16'(desc_reg), 16'(rg));
        chk(req, "rm", 16'(desc_rm), 16'(rm));
        chk(req, "disp", desc_disp, disp);
        chk(req, "imm", desc_imm, imm);
        chk(req, "len", 16'(desc_len), 16'(len));
        @(negedge clk);
        chk("R9", "strobe lasts one cycle", 16'(desc_valid), 16'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "no strobe in reset", 16'(desc_valid), 16'd0);
        chk("R2", "ready low in reset", 16'(in_ready), 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2", "ready after reset", 16'(in_ready), 16'd1);
        chk("R1", "no strobe after reset", 16'(desc_valid), 16'd0);
    endtask

    task automatic t_single;
        put(8'h50); expect_desc("R3", 8'h50, 1'b0, 2'd0, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1);
        put(8'h57); expect_desc("R3", 8'h57, 1'b1, 2'd0, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1);
        put(8'h90); expect_desc("R3", 8'h90, 1'b0, 2'd0, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1);
        put(8'hF5); expect_desc("R3", 8'hF5, 1'b1, 2'd0, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1);
    endtask

    task automatic t_nodisp;
        put(8'h89); put(8'hD8);
        expect_desc("R4", 8'h89, 1'b1, 2'd3, 3'd3, 3'd0, 16'h0, 16'h0, 3'd2);
        put(8'h02); put(8'h2F);
        expect_desc("R5", 8'h02, 1'b0, 2'd0, 3'd5, 3'd7, 16'h0, 16'h0, 3'd2);
    endtask

    task automatic t_short_disp;
        put(8'h8B); put(8'h46); put(8'hFC);
        expect_desc("R6", 8'h8B, 1'b1, 2'd1, 3'd0, 3'd6, 16'hFFFC, 16'h0, 3'd3);
        put(8'h88); put(8'h41); put(8'h05);
        expect_desc("R6", 8'h88, 1'b0, 2'd1, 3'd0, 3'd1, 16'h0005, 16'h0, 3'd3);
    endtask

    task automatic t_long_disp;
        put(8'h8B); put(8'h87); put(8'h34); put(8'h12);
        expect_desc("R7", 8'h8B, 1'b1, 2'd2, 3'd0, 3'd7, 16'h1234, 16'h0, 3'd4);
        put(8'h89); put(8'h36); put(8'h78); put(8'h56);
        expect_desc("R7", 8'h89, 1'b1, 2'd0, 3'd6, 3'd6, 16'h5678, 16'h0, 3'd4);
    endtask

    task automatic t_immediate;
        put(8'hC7); put(8'hC1); put(8'h7A); put(8'h03);
        expect_desc("R8", 8'hC7, 1'b1, 2'd3, 3'd0, 3'd1, 16'h0, 16'h037A, 3'd4);
        put(8'hC6); put(8'h06); put(8'h01); put(8'h30); put(8'hF0);
        expect_desc("R8", 8'hC6, 1'b0, 2'd0, 3'd0, 3'd6, 16'h3001, 16'h00F0, 3'd5);
        put(8'hC7); put(8'h86); put(8'h00); put(8'h50); put(8'hCD); put(8'hAB);
        expect_desc("R8", 8'hC7, 1'b1, 2'd2, 3'd0, 3'd6, 16'h5000, 16'hABCD, 3'd6);
        put(8'hC6); put(8'h45); put(8'h80); put(8'h11);
        expect_desc("R8", 8'hC6, 1'b0, 2'd1, 3'd0, 3'd5, 16'hFF80, 16'h0011, 3'd4);
    endtask

    task automatic t_back_to_back;
        put(8'h90);
        @(negedge clk);
        chk("R9", "first strobe", 16'(desc_valid), 16'd1);
        chk("R9", "first opcode", 16'(desc_opcode), 16'h90);
        in_byte = 8'h89;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "no strobe mid instruction", 16'(desc_valid), 16'd0);
        in_byte = 8'hC3;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "second strobe", 16'(desc_valid), 16'd1);
        chk("R9", "second opcode", 16'(desc_opcode), 16'h89);
        chk("R9", "second len", 16'(desc_len), 16'd2);
        chk("R9", "second rm", 16'(desc_rm), 16'd3);
        in_byte = 8'h52;
        @(posedge clk);
        expect_desc("R9", 8'h52, 1'b0, 2'd0, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1);
    endtask

    task automatic t_gaps;
        put(8'h8B); idle(3);
        put(8'h87); idle(2);
        put(8'h34); idle(4);
        put(8'h12);
        expect_desc("R11", 8'h8B, 1'b1, 2'd2, 3'd0, 3'd7, 16'h1234, 16'h0, 3'd4);
    endtask

    task automatic t_mid_reset;
        put(8'hC7); put(8'h86); put(8'h22);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R10", "no strobe for dropped instruction", 16'(desc_valid), 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "still no strobe", 16'(desc_valid), 16'd0);
        put(8'h90);
        expect_desc("R10", 8'h90, 1'b0, 2'd0, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_nodisp();
        t_short_disp();
        t_long_disp();
        t_immediate();
        t_back_to_back();
        t_gaps();
        t_mid_reset();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule